// File: doc/BRIEF.md
# Inter-Processor Mailbox Channel

This block carries messages in one direction between two processors. The sending processor stores 32-bit words in a bank of message slots and then rings a doorbell. The doorbell drives a level interrupt toward the receiving processor. The receiver reads the slots back and then acknowledges the doorbell through its own port.

Each slot keeps two tracking bits. The lock bit shows that the slot holds data the receiver has not yet fetched. The overwrite bit records that the sender replaced data while the slot was still locked. Either processor can read both bitmaps, so software can check a slot before it writes or reads it.

Both sides use plain register ports. They have no valid/ready handshake and no back-pressure: every access completes in the cycle it is presented. Read data is a combinational function of the port address, which is sampled at the clock edge that ends the access. A write on either port takes effect at that edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every word of the 32-word window reads zero on both ports and `irq` is low.
- R2: A sender write to word n, with n from 4 to 31, stores all 32 data bits. Word n then returns that value on both ports. Words 4 to 23 are the 20 burst slots and words 24 to 31 are the 8 single-word slots.
- R3: A sender write to message word n sets bit n of the lock word (word 1) from the next cycle.
- R4: A receiver read of message word n returns the stored data and clears bit n of word 1 at the end of that cycle. The stored data is kept, so a repeated read returns the same value.
- R5: A sender write to a message word whose lock bit is 1 replaces the data and sets bit n of the overwrite word (word 2). A write to an unlocked word leaves that overwrite bit unchanged.
- R6: A sender write to word 2 clears each overwrite bit whose data bit is 1. Data bits that are 0 leave their overwrite bits unchanged.
- R7: A sender write to word 0 with bit 0 = 1 raises `irq` from the next cycle, and `irq` stays high until acknowledged. A write with bit 0 = 0 has no effect. Word 0 reads as the pending state in bit 0 and zero in bits 31 to 1.
- R8: A receiver write to word 0 with bit 0 = 1 drops `irq` from the next cycle. A receiver write to word 0 with bit 0 = 0 has no effect.
- R9: When a doorbell ring and an acknowledge fall in the same cycle, the ring wins and `irq` is high afterwards.
- R10: When the sender writes message word n in the same cycle that the receiver reads it, the receiver gets the old data. The new data is stored and lock bit n ends at 1.
- R11: Word 3 and bits 3 to 0 of words 1 and 2 always read zero. Sender writes to words 1 and 3 are ignored. Receiver writes to any word other than word 0 are ignored. Apart from the receiver's message reads, reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_wr | input | 1 | Sender write strobe |
| s_addr | input | 5 | Sender word address |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data (combinational on s_addr) |
| r_rd | input | 1 | Receiver read strobe (side effect on message words) |
| r_wr | input | 1 | Receiver write strobe |
| r_addr | input | 5 | Receiver word address |
| r_wdata | input | 32 | Receiver write data (bit 0 used at word 0) |
| r_rdata | output | 32 | Receiver read data (combinational on r_addr) |
| irq | output | 1 | Doorbell interrupt level toward the receiver |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a sender write and a receiver read of the same message slot. The second pair is a doorbell ring and an acknowledge. The bench drives both ports in one cycle for each pair. For the slot collision it checks that the receiver saw the old word, that the new word is stored and that the lock bit is set. For the doorbell collision it checks that `irq` stays high. The bench keeps its own lock and overwrite bitmaps as it sweeps every slot, and it compares the status words against them after each step.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_TRIG = 0;
  localparam int ADDR_LOCK = 1;
  localparam int ADDR_OVW  = 2;
  localparam int ADDR_RSVD = 3;
  localparam int FIRST_MSG = 4;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic              ov_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              lock_q,
  output logic              ov_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      lock_q <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      if (wr) data_q <= wdata;
      // a write wins over a same-cycle read
      if (wr)      lock_q <= 1'b1;
      else if (rd) lock_q <= 1'b0;
      if (wr && lock_q) ov_q <= 1'b1;
      else if (ov_clr)  ov_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic ring,
  input  logic ack,
  output logic pending_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending_q <= 1'b0;
    else if (ring) pending_q <= 1'b1;
    else if (ack)  pending_q <= 1'b0;
  end
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
  import mbox_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_MSG = 28,
  parameter int AW      = 5
) (
  input  logic [AW-1:0]             addr,
  input  logic                      pending,
  input  logic [DATA_W-1:0]         lock_vec,
  input  logic [DATA_W-1:0]         ov_vec,
  input  logic [NUM_MSG*DATA_W-1:0] msg_flat,
  output logic [DATA_W-1:0]         rdata
);
  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_TRIG))      rdata = {{(DATA_W-1){1'b0}}, pending};
    else if (addr == AW'(ADDR_LOCK)) rdata = lock_vec;
    else if (addr == AW'(ADDR_OVW))  rdata = ov_vec;
    for (int g = 0; g < NUM_MSG; g++) begin
      if (addr == AW'(FIRST_MSG + g)) rdata = msg_flat[g*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_NORMAL = 20,
  parameter int NUM_DIRECT = 8,
  localparam int NUM_MSG   = NUM_NORMAL + NUM_DIRECT,
  localparam int WORDS     = FIRST_MSG + NUM_MSG,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_wr,
  input  logic [AW-1:0]     s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  input  logic              r_rd,
  input  logic              r_wr,
  input  logic [AW-1:0]     r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              irq
);
  logic [DATA_W-1:0]         lock_vec;
  logic [DATA_W-1:0]         ov_vec;
  logic [NUM_MSG*DATA_W-1:0] msg_flat;
  logic                      pending;
  logic                      ring, ack, ov_wr;
  logic                      unused_rx_bits;

  assign ring  = s_wr && (s_addr == AW'(ADDR_TRIG)) && s_wdata[0];
  assign ack   = r_wr && (r_addr == AW'(ADDR_TRIG)) && r_wdata[0];
  assign ov_wr = s_wr && (s_addr == AW'(ADDR_OVW));
  assign unused_rx_bits = ^r_wdata[DATA_W-1:1];

  assign lock_vec[FIRST_MSG-1:0] = '0;
  assign ov_vec[FIRST_MSG-1:0]   = '0;
  if (WORDS < DATA_W) begin : g_pad
    assign lock_vec[DATA_W-1:WORDS] = '0;
    assign ov_vec[DATA_W-1:WORDS]   = '0;
  end

  for (genvar g = 0; g < NUM_MSG; g++) begin : g_slot
    localparam int IDX = FIRST_MSG + g;
    mbox_slot #(.DATA_W(DATA_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (s_wr && (s_addr == AW'(IDX))),
      .rd     (r_rd && (r_addr == AW'(IDX))),
      .ov_clr (ov_wr && s_wdata[IDX]),
      .wdata  (s_wdata),
      .data_q (msg_flat[g*DATA_W +: DATA_W]),
      .lock_q (lock_vec[IDX]),
      .ov_q   (ov_vec[IDX])
    );
  end

  mbox_doorbell u_bell (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring      (ring),
    .ack       (ack),
    .pending_q (pending)
  );
  assign irq = pending;

  mbox_rdmux #(.DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .AW(AW)) u_smux (
    .addr(s_addr), .pending(pending), .lock_vec(lock_vec), .ov_vec(ov_vec),
    .msg_flat(msg_flat), .rdata(s_rdata)
  );
  mbox_rdmux #(.DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .AW(AW)) u_rmux (
    .addr(r_addr), .pending(pending), .lock_vec(lock_vec), .ov_vec(ov_vec),
    .msg_flat(msg_flat), .rdata(r_rdata)
  );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int WORDS  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_wr,
  input logic [AW-1:0]     s_addr,
  input logic              s_bit0,
  input logic              r_rd,
  input logic              r_wr,
  input logic [AW-1:0]     r_addr,
  input logic              r_bit0,
  input logic              irq,
  input logic [DATA_W-1:0] lock_vec,
  input logic [DATA_W-1:0] ov_vec
);
  logic s_msg, r_msg, ring, ack;
  assign s_msg = s_wr && (int'(s_addr) >= FIRST_MSG) && (int'(s_addr) < WORDS);
  assign r_msg = r_rd && (int'(r_addr) >= FIRST_MSG) && (int'(r_addr) < WORDS);
  assign ring  = s_wr && (s_addr == AW'(ADDR_TRIG)) && s_bit0;
  assign ack   = r_wr && (r_addr == AW'(ADDR_TRIG)) && r_bit0;

  assert_lock_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_msg |=> lock_vec[$past(s_addr)]);

  assert_read_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_msg && !(s_wr && s_addr == r_addr)) |=> !lock_vec[$past(r_addr)]);

  assert_overwrite_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_msg && lock_vec[s_addr]) |=> ov_vec[$past(s_addr)]);

  assert_ring_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring |=> irq);

  assert_irq_drop_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ack));

  assert_ring_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ring && ack) |=> irq);

  assert_collision_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_msg && r_rd && s_addr == r_addr) |=> lock_vec[$past(s_addr)]);

  assert_low_bits_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vec[FIRST_MSG-1:0] == '0) && (ov_vec[FIRST_MSG-1:0] == '0));
endmodule

bind ipc_mailbox mbox_chk #(.DATA_W(DATA_W), .AW(AW), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_wr(s_wr), .s_addr(s_addr), .s_bit0(s_wdata[0]),
  .r_rd(r_rd), .r_wr(r_wr), .r_addr(r_addr), .r_bit0(r_wdata[0]), .irq(irq),
  .lock_vec(lock_vec), .ov_vec(ov_vec)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_wr = 1'b0, r_rd = 1'b0, r_wr = 1'b0;
  logic [4:0]  s_addr = '0, r_addr = '0;
  logic [31:0] s_wdata = '0, r_wdata = '0;
  logic [31:0] s_rdata, r_rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_lock = '0, exp_ov = '0;
  logic [31:0] got;

  always #4 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .r_rd(r_rd), .r_wr(r_wr), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .irq(irq)
  );

  function automatic logic [31:0] pat1(int k);
    return {8'hC3, 8'(k), 16'(k * k * 7 + 1)};
  endfunction
  function automatic logic [31:0] pat2(int k);
    return ~pat1(k) ^ (32'(k) << 9);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic s_write(int a, logic [31:0] d);
    @(negedge clk); s_wr = 1'b1; s_addr = 5'(a); s_wdata = d;
    @(negedge clk); s_wr = 1'b0;
  endtask
  task automatic r_write(int a, logic [31:0] d);
    @(negedge clk); r_wr = 1'b1; r_addr = 5'(a); r_wdata = d;
    @(negedge clk); r_wr = 1'b0;
  endtask
  task automatic s_peek(int a, output logic [31:0] d);
    s_addr = 5'(a); #1 d = s_rdata;
  endtask
  task automatic r_peek(int a, output logic [31:0] d);
    r_addr = 5'(a); #1 d = r_rdata;
  endtask
  task automatic r_read(int a, output logic [31:0] d);
    @(negedge clk); r_rd = 1'b1; r_addr = 5'(a); #1 d = r_rdata;
    @(negedge clk); r_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of the whole window
    for (int a = 0; a < 32; a++) begin
      s_peek(a, got); check("R1 sender word", got, 32'h0);
      r_peek(a, got); check("R1 receiver word", got, 32'h0);
    end
    check("R1 irq", 32'(irq), 32'h0);

    // R2/R3/R5: first write to each slot, then overwrite
    for (int k = 4; k < 32; k++) begin
      s_write(k, pat1(k));
      exp_lock[k] = 1'b1;
      s_peek(k, got); check("R2 stored data", got, pat1(k));
      s_peek(1, got); check("R3 lock word", got, exp_lock);
      s_peek(2, got); check("R5 no overwrite on unlocked", got, exp_ov);
      s_write(k, pat2(k));
      exp_ov[k] = 1'b1;
      r_peek(k, got); check("R5 replaced data", got, pat2(k));
      r_peek(2, got); check("R5 overwrite word", got, exp_ov);
    end

    // R11: ignored writes and zero fields
    s_write(1, 32'hFFFF_FFFF);
    s_peek(1, got); check("R11 lock word write ignored", got, exp_lock);
    s_write(3, 32'hFFFF_FFFF);
    s_peek(3, got); check("R11 reserved word", got, 32'h0);
    r_write(5, 32'h1234_5678);
    r_peek(5, got); check("R11 receiver write to message", got, pat2(5));
    r_write(2, 32'hFFFF_FFFF);
    s_peek(2, got); check("R11 receiver write to overwrite word", got, exp_ov);
    s_peek(1, got); check("R11 lock unchanged", got, exp_lock);

    // R6: write-1-to-clear of overwrite bits
    s_write(2, 32'h0000_FF0F);
    exp_ov &= ~32'h0000_FF0F;
    s_peek(2, got); check("R6 partial clear", got, exp_ov);
    s_write(2, 32'h0);
    s_peek(2, got); check("R6 zero write no effect", got, exp_ov);
    s_write(2, 32'hFFFF_FFFF);
    exp_ov = '0;
    s_peek(2, got); check("R6 full clear", got, 32'h0);

    // R4: receiver reads clear locks one by one; data survives
    for (int k = 4; k < 32; k++) begin
      r_read(k, got); check("R4 read data", got, pat2(k));
      exp_lock[k] = 1'b0;
      s_peek(1, got); check("R4 lock cleared", got, exp_lock);
      r_read(k, got); check("R4 repeat read", got, pat2(k));
    end
    r_read(1, got); check("R11 status read side-effect free", got, 32'h0);

    // R7/R8: doorbell
    s_write(0, 32'hFFFF_FFFE);
    check("R7 zero bit no ring", 32'(irq), 32'h0);
    s_write(0, 32'hFFFF_FFFF);
    check("R7 ring raises irq", 32'(irq), 32'h1);
    s_peek(0, got); check("R7 trigger word readback", got, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 irq held", 32'(irq), 32'h1);
    r_write(0, 32'hFFFF_FFFE);
    check("R8 ack with bit0 clear no effect", 32'(irq), 32'h1);
    r_write(0, 32'h1);
    check("R8 ack drops irq", 32'(irq), 32'h0);
    r_peek(0, got); check("R8 trigger word cleared", got, 32'h0);

    // R9: ring and ack in the same cycle
    @(negedge clk);
    s_wr = 1'b1; s_addr = 5'd0; s_wdata = 32'h1;
    r_wr = 1'b1; r_addr = 5'd0; r_wdata = 32'h1;
    @(negedge clk); s_wr = 1'b0; r_wr = 1'b0;
    check("R9 ring beats ack", 32'(irq), 32'h1);

    // R10: sender write and receiver read of the same slot
    for (int k = 4; k < 32; k += 9) begin
      @(negedge clk);
      s_wr = 1'b1; s_addr = 5'(k); s_wdata = pat1(k);
      r_rd = 1'b1; r_addr = 5'(k);
      #1 got = r_rdata;
      @(negedge clk); s_wr = 1'b0; r_rd = 1'b0;
      exp_lock[k] = 1'b1;
      check("R10 receiver sees old data", got, pat2(k));
      s_peek(k, got); check("R10 new data stored", got, pat1(k));
      s_peek(1, got); check("R10 lock ends set", got, exp_lock);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule